// File: doc/BRIEF.md
# Bus-Based Multi-Cycle Mini Processor

This block is a small multi-cycle processor core. It holds four general registers, an operand register A, an ALU and a result register G. All of them share a single data bus. A start strobe in the idle state captures a 7-bit instruction. The core then runs the instruction as a short series of bus transfers and raises a one-cycle completion pulse. A load takes its value from an external data input. Instruction fetch and sequencing belong to the surrounding logic.

The control side has three parts. An instruction register holds the captured word. Two enabled one-hot decoders turn a register field into a write strobe and a read select. A four-state machine steps through the transfers. The bus is a multiplexer, and at most one source drives it in any cycle. The bus is also brought out as an output, so the value written into the destination register can be seen in the cycle of the completion pulse.

Top module: `bus_mini_cpu`

## Requirements
- R1: After an asynchronous reset, done_o is 0, bus_o is 0 and all four registers hold 0.
- R2: The instruction word has its opcode in bits [6:4], the second-source select Ry in bits [3:2] and the destination select Rx in bits [1:0]. The word is captured only when start_i is 1 in the idle state.
- R3: Opcode 000 writes ext_data_i into Rx. done_o rises in the first cycle after the capture edge.
- R4: Opcode 001 copies Ry into Rx. done_o rises in the first cycle after the capture edge.
- R5: Opcode 010 writes Rx+Ry and opcode 011 writes Rx-Ry, both modulo 2^DW. Each takes three cycles: Rx into A, then the ALU result into G, then G into Rx with done_o.
- R6: Opcode 100 writes the bitwise NOT of Rx into Rx in three cycles. The Ry field has no effect.
- R7: Opcodes 101, 110 and 111 write Rx AND Ry, Rx OR Ry and Rx XOR Ry into Rx, each in three cycles.
- R8: done_o is high for exactly one cycle, and the core is idle in the next cycle. During the done_o cycle, bus_o carries the value being written into Rx.
- R9: While an instruction is executing, start_i and instr_i are ignored. No register other than the current Rx changes.
- R10: At most one source drives the bus in any cycle. When no source drives it, bus_o is 0, as it is in idle.
- R11: Only the register selected by Rx is written, and only in the cycle where done_o is high.
- R12: When Rx equals Ry, a two-operand instruction uses the same register for both operands. For example, Rx-Rx gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; captures instr_i when the core is idle |
| instr_i | input | 7 | Instruction word: {opcode[2:0], Ry[1:0], Rx[1:0]} |
| ext_data_i | input | DW | External operand for the load instruction |
| done_o | output | 1 | One-cycle completion pulse |
| bus_o | output | DW | Current value of the shared data bus |

## Verification
The assertions assume that ext_data_i is held steady from the capture edge through the execute cycle of a load. They also assume that start_i is driven to a known level on every clock edge. The bench drives inputs only on falling edges. It keeps the load data unchanged until the instruction completes, and it raises start_i mid-instruction only to show that it is ignored. The bench reads registers with a move of a register onto itself, which leaves all state unchanged.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_EXEC,
      ST_OPER,
      ST_WB
   } state_e;

   typedef enum logic [2:0] {
      OP_LOAD = 3'b000,
      OP_MOVE = 3'b001,
      OP_ADD  = 3'b010,
      OP_SUB  = 3'b011,
      OP_NOT  = 3'b100,
      OP_AND  = 3'b101,
      OP_OR   = 3'b110,
      OP_XOR  = 3'b111
   } opcode_e;

   typedef enum logic [3:0] {
      ALU_PASS_A = 4'b0000,
      ALU_INC_A  = 4'b0001,
      ALU_DEC_A  = 4'b0010,
      ALU_PASS_B = 4'b0011,
      ALU_INC_B  = 4'b0100,
      ALU_DEC_B  = 4'b0101,
      ALU_ADD    = 4'b0110,
      ALU_SUB    = 4'b0111,
      ALU_NOT_A  = 4'b1000,
      ALU_NOT_B  = 4'b1001,
      ALU_AND    = 4'b1010,
      ALU_OR     = 4'b1011,
      ALU_NAND   = 4'b1100,
      ALU_NOR    = 4'b1101,
      ALU_XOR    = 4'b1110,
      ALU_XNOR   = 4'b1111
   } alu_op_e;

   typedef struct packed {
      logic    wr_en;    // write the Rx register from the bus
      logic    rd_en;    // drive a register onto the bus
      logic    rd_ry;    // read select: 1 = Ry field, 0 = Rx field
      logic    ext_drv;  // external data drives the bus
      logic    g_drv;    // G drives the bus
      logic    a_ld;     // load A from the bus
      logic    g_ld;     // load G from the ALU
      logic    done;
      alu_op_e alu_op;
   } ctrl_t;

endpackage

// File: rtl/bmc_alu.sv
module bmc_alu
   import bmc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   input  alu_op_e       op_i,
   output logic [DW-1:0] y_o
);

   localparam logic [DW-1:0] ONE = DW'(1);

   always_comb begin
      unique case (op_i)
         ALU_PASS_A: y_o = a_i;
         ALU_INC_A:  y_o = a_i + ONE;
         ALU_DEC_A:  y_o = a_i - ONE;
         ALU_PASS_B: y_o = b_i;
         ALU_INC_B:  y_o = b_i + ONE;
         ALU_DEC_B:  y_o = b_i - ONE;
         ALU_ADD:    y_o = a_i + b_i;
         ALU_SUB:    y_o = a_i - b_i;
         ALU_NOT_A:  y_o = ~a_i;
         ALU_NOT_B:  y_o = ~b_i;
         ALU_AND:    y_o = a_i & b_i;
         ALU_OR:     y_o = a_i | b_i;
         ALU_NAND:   y_o = ~(a_i & b_i);
         ALU_NOR:    y_o = ~(a_i | b_i);
         ALU_XOR:    y_o = a_i ^ b_i;
         ALU_XNOR:   y_o = ~(a_i ^ b_i);
         default:    y_o = a_i;
      endcase
   end

endmodule

// File: rtl/bmc_dec.sv
module bmc_dec #(
   parameter int SEL_W = 2
) (
   input  logic                en_i,
   input  logic [SEL_W-1:0]    sel_i,
   output logic [2**SEL_W-1:0] hot_o
);

   localparam int N_OUT = 2**SEL_W;

   for (genvar i = 0; i < N_OUT; i++) begin : g_out
      assign hot_o[i] = en_i && (sel_i == SEL_W'(i));
   end

endmodule

// File: rtl/bmc_ctrl.sv
module bmc_ctrl
   import bmc_pkg::*;
#(
   parameter int RSEL_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [2*RSEL_W+2:0]   instr_i,
   output ctrl_t                 ctl_o,
   output logic [RSEL_W-1:0]     rx_o,
   output logic [RSEL_W-1:0]     ry_o,
   output logic                  busy_o,
   output logic [2*RSEL_W+2:0]   ir_o
);

   localparam int IW = 2*RSEL_W + 3;

   state_e          state_q;
   logic [IW-1:0]   ir_q;
   opcode_e         opc;

   assign opc    = opcode_e'(ir_q[IW-1 -: 3]);
   assign rx_o   = ir_q[RSEL_W-1:0];
   assign ry_o   = ir_q[2*RSEL_W-1:RSEL_W];
   assign busy_o = (state_q != ST_IDLE);
   assign ir_o   = ir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ir_q    <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               ir_q    <= instr_i;
               state_q <= ST_EXEC;
            end
            ST_EXEC: state_q <= (opc == OP_LOAD || opc == OP_MOVE) ? ST_IDLE : ST_OPER;
            ST_OPER: state_q <= ST_WB;
            ST_WB:   state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   function automatic alu_op_e alu_map(opcode_e o);
      unique case (o)
         OP_ADD:  return ALU_ADD;
         OP_SUB:  return ALU_SUB;
         OP_NOT:  return ALU_NOT_A;
         OP_AND:  return ALU_AND;
         OP_OR:   return ALU_OR;
         OP_XOR:  return ALU_XOR;
         default: return ALU_PASS_A;
      endcase
   endfunction

   always_comb begin
      ctl_o = '0;
      unique case (state_q)
         ST_EXEC: begin
            if (opc == OP_LOAD) begin
               ctl_o.ext_drv = 1'b1;
               ctl_o.wr_en   = 1'b1;
               ctl_o.done    = 1'b1;
            end else if (opc == OP_MOVE) begin
               ctl_o.rd_en   = 1'b1;
               ctl_o.rd_ry   = 1'b1;
               ctl_o.wr_en   = 1'b1;
               ctl_o.done    = 1'b1;
            end else begin
               ctl_o.rd_en   = 1'b1;
               ctl_o.a_ld    = 1'b1;
            end
         end
         ST_OPER: begin
            ctl_o.g_ld   = 1'b1;
            ctl_o.alu_op = alu_map(opc);
            if (opc != OP_NOT) begin
               ctl_o.rd_en = 1'b1;
               ctl_o.rd_ry = 1'b1;
            end
         end
         ST_WB: begin
            ctl_o.g_drv = 1'b1;
            ctl_o.wr_en = 1'b1;
            ctl_o.done  = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/bus_mini_cpu.sv
module bus_mini_cpu
   import bmc_pkg::*;
#(
   parameter int DW     = 8,
   parameter int RSEL_W = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [2*RSEL_W+2:0] instr_i,
   input  logic [DW-1:0]       ext_data_i,
   output logic                done_o,
   output logic [DW-1:0]       bus_o
);

   localparam int NREG = 2**RSEL_W;
   localparam int IW   = 2*RSEL_W + 3;

   if (DW < 1) begin : g_bad_dw
      $error("bus_mini_cpu: DW must be at least 1");
   end
   if (RSEL_W < 1 || RSEL_W > 4) begin : g_bad_rsel
      $error("bus_mini_cpu: RSEL_W must be 1 to 4");
   end

   ctrl_t               ctl;
   logic [RSEL_W-1:0]   rx, ry, rd_idx;
   logic                busy;
   logic [IW-1:0]       ir;
   logic [NREG-1:0]     wr_sel, rd_sel;
   logic [DW-1:0]       rf_q [NREG];
   logic [DW-1:0]       a_q, g_q, alu_y, rf_bus, bus;

   bmc_ctrl #(.RSEL_W(RSEL_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .instr_i (instr_i),
      .ctl_o   (ctl),
      .rx_o    (rx),
      .ry_o    (ry),
      .busy_o  (busy),
      .ir_o    (ir)
   );

   assign rd_idx = ctl.rd_ry ? ry : rx;

   bmc_dec #(.SEL_W(RSEL_W)) u_wr_dec (
      .en_i  (ctl.wr_en),
      .sel_i (rx),
      .hot_o (wr_sel)
   );

   bmc_dec #(.SEL_W(RSEL_W)) u_rd_dec (
      .en_i  (ctl.rd_en),
      .sel_i (rd_idx),
      .hot_o (rd_sel)
   );

   always_comb begin
      rf_bus = '0;
      for (int i = 0; i < NREG; i++) begin
         if (rd_sel[i]) rf_bus = rf_bus | rf_q[i];
      end
   end

   always_comb begin
      if (ctl.ext_drv)    bus = ext_data_i;
      else if (ctl.g_drv) bus = g_q;
      else                bus = rf_bus;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
      end else begin
         for (int i = 0; i < NREG; i++) begin
            if (wr_sel[i]) rf_q[i] <= bus;
         end
      end
   end

   bmc_alu #(.DW(DW)) u_alu (
      .a_i  (a_q),
      .b_i  (bus),
      .op_i (ctl.alu_op),
      .y_o  (alu_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         g_q <= '0;
      end else begin
         if (ctl.a_ld) a_q <= bus;
         if (ctl.g_ld) g_q <= alu_y;
      end
   end

   assign done_o = ctl.done;
   assign bus_o  = bus;

endmodule

// File: rtl/bmc_chk.sv
module bmc_chk #(
   parameter int DW     = 8,
   parameter int RSEL_W = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start_i,
   input logic                  busy,
   input logic                  done_o,
   input logic [2**RSEL_W-1:0]  wr_sel,
   input logic [2**RSEL_W-1:0]  rd_sel,
   input logic                  ext_drv,
   input logic                  g_drv,
   input logic                  rd_en,
   input logic                  a_ld,
   input logic                  g_ld,
   input logic [2*RSEL_W+2:0]   ir
);

   // R2
   start_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy) |=> busy);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy);

   // R9
   ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(ir));

   // R10
   bus_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ext_drv, g_drv, rd_en}) <= 1);

   // R10
   rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_sel));

   // R11
   wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel));

   // R11
   wr_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel != '0) |-> done_o);

   // R5
   g_after_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      g_ld |-> $past(a_ld));

endmodule

bind bus_mini_cpu bmc_chk #(.DW(DW), .RSEL_W(RSEL_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .busy    (busy),
   .done_o  (done_o),
   .wr_sel  (wr_sel),
   .rd_sel  (rd_sel),
   .ext_drv (ctl.ext_drv),
   .g_drv   (ctl.g_drv),
   .rd_en   (ctl.rd_en),
   .a_ld    (ctl.a_ld),
   .g_ld    (ctl.g_ld),
   .ir      (ir)
);

// File: tb/test_bus_mini_cpu.sv
module test_bus_mini_cpu;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [6:0] instr_i = '0;
   logic [7:0] ext_data_i = '0;
   logic       done_o;
   logic [7:0] bus_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   bus_mini_cpu #(.DW(8), .RSEL_W(2)) i_bus_mini_cpu (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .instr_i    (instr_i),
      .ext_data_i (ext_data_i),
      .done_o     (done_o),
      .bus_o      (bus_o)
   );

   // {instr[6:0], ext_data[7:0], expected value written to Rx[7:0]}
   localparam int NVEC = 15;
   localparam logic [22:0] VEC [NVEC] = '{
      {7'b000_00_00, 8'h5A, 8'h5A},  // load  R0 <- 5A
      {7'b000_00_01, 8'h33, 8'h33},  // load  R1 <- 33
      {7'b000_00_10, 8'hF0, 8'hF0},  // load  R2 <- F0
      {7'b000_00_11, 8'h0F, 8'h0F},  // load  R3 <- 0F
      {7'b010_01_00, 8'hC3, 8'h8D},  // add   R0 = 5A+33
      {7'b011_00_01, 8'hC3, 8'hA6},  // sub   R1 = 33-8D wraps
      {7'b101_00_10, 8'hC3, 8'h80},  // and   R2 = F0&8D
      {7'b110_01_11, 8'hC3, 8'hAF},  // or    R3 = 0F|A6
      {7'b111_11_00, 8'hC3, 8'h22},  // xor   R0 = 8D^AF
      {7'b100_10_01, 8'hC3, 8'h59},  // not   R1 = ~A6, Ry field ignored
      {7'b001_11_10, 8'hC3, 8'hAF},  // move  R2 <- R3
      {7'b010_11_11, 8'hC3, 8'h5E},  // add   R3 = AF+AF wraps
      {7'b011_10_10, 8'hC3, 8'h00},  // sub   R2 = R2-R2
      {7'b000_00_00, 8'hFF, 8'hFF},  // load  R0 <- FF
      {7'b010_01_00, 8'hC3, 8'h58}   // add   R0 = FF+59 wraps
   };

   function automatic string tag_of(input logic [2:0] op, input logic [1:0] rx, input logic [1:0] ry);
      if (op == 3'b000) return "R3";
      if (op == 3'b001) return "R4";
      if ((op == 3'b010 || op == 3'b011) && rx == ry) return "R12";
      if (op == 3'b010 || op == 3'b011) return "R5";
      if (op == 3'b100) return "R6";
      return "R7";
   endfunction

   task automatic check_eq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_instr(input logic [6:0] ins, input logic [7:0] d, input logic [7:0] exp,
                            input string req, input bit hold);
      int lat = (ins[6:5] == 2'b00) ? 1 : 3;
      int n;
      @(negedge clk);
      start_i = 1'b1;
      instr_i = ins;
      ext_data_i = d;
      @(negedge clk);
      if (hold) begin
         instr_i = 7'b000_00_11;   // a load into R3 that must not take effect
         ext_data_i = 8'h77;
      end else begin
         start_i = 1'b0;
      end
      n = 1;
      while (!done_o && n < 8) begin
         @(negedge clk);
         n++;
      end
      check_eq(req, "done latency", 32'(n), 32'(lat));
      check_eq(req, "bus at done (R8)", 32'(bus_o), 32'(exp));
      start_i = 1'b0;
      @(negedge clk);
      check_eq("R8", "done after pulse", 32'(done_o), 32'd0);
   endtask

   task automatic read_reg(input logic [1:0] r, input logic [7:0] exp, input string req);
      run_instr({3'b001, r, r}, 8'h00, exp, req, 1'b0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      check_eq("R1", "done in reset", 32'(done_o), 32'd0);
      check_eq("R1", "bus in reset", 32'(bus_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int r = 0; r < 4; r++) read_reg(2'(r), 8'h00, "R1");

      // R10: idle with start low: nothing drives the bus, no completion
      repeat (3) begin
         @(negedge clk);
         check_eq("R10", "idle bus", 32'(bus_o), 32'd0);
         check_eq("R2", "idle done without start", 32'(done_o), 32'd0);
      end

      // main vector table (R2 field positions exercised by varied Rx/Ry)
      for (int v = 0; v < NVEC; v++) begin
         logic [6:0] ins;
         ins = VEC[v][22:16];
         run_instr(ins, VEC[v][15:8], VEC[v][7:0],
                   tag_of(ins[6:4], ins[1:0], ins[3:2]), 1'b0);
      end

      // R11: final register contents, only the selected Rx was ever written
      read_reg(2'd0, 8'h58, "R11");
      read_reg(2'd1, 8'h59, "R11");
      read_reg(2'd2, 8'h00, "R11");
      read_reg(2'd3, 8'h5E, "R11");

      // R9: start held high during an add with a load into R3 presented
      run_instr(7'b010_00_10, 8'h00, 8'h58, "R9", 1'b1);
      read_reg(2'd3, 8'h5E, "R9");
      read_reg(2'd2, 8'h58, "R9");
      read_reg(2'd0, 8'h58, "R9");

      // R3: ext data ignored for a non-load instruction (move of R1)
      run_instr(7'b001_01_01, 8'hEE, 8'h59, "R3", 1'b0);

      // R10: back to idle, bus quiet
      @(negedge clk);
      check_eq("R10", "idle bus after run", 32'(bus_o), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule